// File: doc/BRIEF.md
# Serial Command Front End for a Digital Potentiometer

This block is the control side of a digitally set resistor. A host shifts 24-bit command words into it over a three-wire serial link made of a clock, a data line and an active-low select. The word is decoded only when the select line returns high. The four most significant bits carry the command, the next four carry a target address, and the lowest sixteen carry data. The block keeps a 10-bit wiper scratchpad that sets the resistor tap. It also keeps a nonvolatile shadow, made of a stored wiper value and two stored general-purpose output bits. The shadow is modelled with ordinary registers and given a fixed, parameterised write time.

All serial inputs are resynchronised to the system clock and edge-detected. The serial output has two jobs. Normally it replays the previous frame 24 serial clocks late, so that several devices can be chained. After a readback command it carries the requested value during the next frame instead. A ready flag is low while a store, reload or readback is in progress. A write-protect input locks the stored and live state. A preset input, on its rising edge, reloads the wiper from the stored copy.

Top module: `dpot_serial_ctrl`

## Requirements
- R1: After reset the wiper is 512, the stored wiper copy is 512, both general outputs are 0, ready is high and the serial output is 0.
- R2: Bits are taken on each serial clock rising edge while select is low, most significant bit first. On the select rising edge a frame of exactly 24 bits executes, with the command in bits 23:20, the address in bits 19:16 and the data in bits 15:0. Command 11 with address 0 writes the wiper at once. Commands 0, 4 to 7 and 12 to 15 change nothing, and neither does command 11 with a nonzero address.
- R3: A value written to the wiper is clamped to 1023 when the 16-bit data exceeds 1023.
- R4: A frame whose bit count is not exactly 24 when select rises is discarded.
- R5: Outside readback, the serial output presents the bits of the previous frame during the next one, in shift order, so the bit seen before the n-th rising edge is bit 24-n of the earlier frame.
- R6: Command 2 copies the wiper into the stored copy and holds ready low for exactly STORE_CYC system clocks. Command 1 copies the stored wiper into the wiper at once, with ready staying high.
- R7: Command 3 with address 1 stores data bits 1:0 into the stored output bits, which drive gpo[0] and gpo[1]. With address 0 it stores the clamped data as the stored wiper. Both hold ready low for STORE_CYC clocks and take effect when ready rises.
- R8: Commands 9 and 10 hold ready low for LOAD_CYC clocks. They then replace the echo with a readback word that is shifted out during the next frame, most significant bit first. Command 9 reads the stored copy and command 10 reads the live state. With address 0 the word is the wiper value in bits 9:0. With address 1 it is the output bits in bits 1:0. All other bits are zero.
- R9: While wp_n is low, commands 2, 3 and 11 have no effect and do not lower ready. Commands 1, 8, 9 and 10 and the preset input still operate.
- R10: A rising edge on preset reloads the wiper from the stored copy after ready has been low for LOAD_CYC clocks.
- R11: A frame that ends while ready is low is ignored, and the running operation keeps its length.
- R12: Command 8 reloads the wiper from the stored copy after ready has been low for LOAD_CYC clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select |
| wp_n | input | 1 | Active-low write protect |
| preset | input | 1 | Reload request, acts on its rising edge |
| sdo | output | 1 | Serial data out (echo or readback) |
| rdy | output | 1 | High when idle |
| wiper | output | 10 | Wiper scratchpad value |
| gpo | output | 2 | Stored general outputs |

## Verification
The bench builds the block with STORE_CYC set to 400 and LOAD_CYC set to 5. A store is then longer than one full 24-bit frame at the bench's serial rate, so a second frame can finish while the store is still busy. This reaches the frame-ignored-while-busy case. The short reload window keeps the number of readback and preset cycles small, and the exact count of ready-low clocks is still checked for both lengths. Random wiper writes cover data on both sides of the clamp limit, and periodic readbacks confirm them.

// File: rtl/dpot_serial_ctrl.sv
module dpot_serial_ctrl #(
  parameter int WIPER_W   = 10,
  parameter int FRAME_W   = 24,
  parameter int STORE_CYC = 2000,
  parameter int LOAD_CYC  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sdi,
  input  logic               cs_n,
  input  logic               wp_n,
  input  logic               preset,
  output logic               sdo,
  output logic               rdy,
  output logic [WIPER_W-1:0] wiper,
  output logic [1:0]         gpo
);
  localparam int DATA_W  = FRAME_W - 8;
  localparam int WMAX    = (1 << WIPER_W) - 1;
  localparam int WMID    = 1 << (WIPER_W - 1);
  localparam int CNT_MAX = (STORE_CYC > LOAD_CYC) ? STORE_CYC : LOAD_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BC_W    = $clog2(FRAME_W + 2);

  typedef enum logic [2:0] {OP_IDLE, OP_STW, OP_STD, OP_RELOAD, OP_RBNV, OP_RBLIVE} op_t;

  logic [2:0] sclk_q, cs_q, pr_q;
  logic [1:0] sdi_q, wp_q;
  logic [FRAME_W-1:0] shreg;
  logic [BC_W-1:0]    bitcnt;
  logic [WIPER_W-1:0] nv_w;
  logic [1:0]         nv_o;
  logic [CNT_W-1:0]   busy;
  op_t                op;
  logic [3:0]         op_addr;
  logic [DATA_W-1:0]  op_data;

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire cs_rise   = cs_q[1] & ~cs_q[2];
  wire cs_fall   = ~cs_q[1] & cs_q[2];
  wire pr_rise   = pr_q[1] & ~pr_q[2];
  wire wp_ok     = wp_q[1];
  wire [3:0] f_cmd  = shreg[FRAME_W-1 -: 4];
  wire [3:0] f_addr = shreg[FRAME_W-5 -: 4];
  wire [DATA_W-1:0] f_data = shreg[DATA_W-1:0];
  wire frame_ok = cs_rise && (bitcnt == BC_W'(FRAME_W));
  wire idle     = (busy == '0);
  wire frame_go = frame_ok && idle;

  assign sdo   = shreg[FRAME_W-1];
  assign rdy   = idle;
  assign gpo   = nv_o;

  function automatic logic [WIPER_W-1:0] clampw(input logic [DATA_W-1:0] d);
    if (d > DATA_W'(WMAX)) return WIPER_W'(WMAX);
    return d[WIPER_W-1:0];
  endfunction

  function automatic logic [FRAME_W-1:0] rb_word(input logic live, input logic [3:0] a);
    logic [FRAME_W-1:0] r;
    r = '0;
    if (a == 4'd0) r[WIPER_W-1:0] = live ? wiper : nv_w;
    else if (a == 4'd1) r[1:0] = nv_o;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= '0;
      cs_q    <= '1;
      pr_q    <= '1;
      sdi_q   <= '0;
      wp_q    <= '1;
      shreg   <= '0;
      bitcnt  <= '0;
      nv_w    <= WIPER_W'(WMID);
      nv_o    <= '0;
      wiper   <= WIPER_W'(WMID);
      busy    <= '0;
      op      <= OP_IDLE;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      pr_q   <= {pr_q[1:0], preset};
      sdi_q  <= {sdi_q[0], sdi};
      wp_q   <= {wp_q[0], wp_n};

      if (cs_fall) begin
        bitcnt <= '0;
      end else if (sclk_rise && !cs_q[1]) begin
        shreg <= {shreg[FRAME_W-2:0], sdi_q[1]};
        if (bitcnt != BC_W'(FRAME_W + 1)) bitcnt <= bitcnt + 1'b1;
      end

      if (!idle) begin
        busy <= busy - 1'b1;
        if (busy == CNT_W'(1)) begin
          op <= OP_IDLE;
          case (op)
            OP_STW:    nv_w <= wiper;
            OP_STD: begin
              if (op_addr == 4'd0) nv_w <= clampw(op_data);
              else if (op_addr == 4'd1) nv_o <= op_data[1:0];
            end
            OP_RELOAD: wiper <= nv_w;
            OP_RBNV:   shreg <= rb_word(1'b0, op_addr);
            OP_RBLIVE: shreg <= rb_word(1'b1, op_addr);
            default: ;
          endcase
        end
      end else if (frame_go) begin
        op_addr <= f_addr;
        op_data <= f_data;
        case (f_cmd)
          4'd1: wiper <= nv_w;
          4'd2: if (wp_ok) begin
            op   <= OP_STW;
            busy <= CNT_W'(STORE_CYC);
          end
          4'd3: if (wp_ok) begin
            op   <= OP_STD;
            busy <= CNT_W'(STORE_CYC);
          end
          4'd8: begin
            op   <= OP_RELOAD;
            busy <= CNT_W'(LOAD_CYC);
          end
          4'd9: begin
            op   <= OP_RBNV;
            busy <= CNT_W'(LOAD_CYC);
          end
          4'd10: begin
            op   <= OP_RBLIVE;
            busy <= CNT_W'(LOAD_CYC);
          end
          4'd11: if (wp_ok && f_addr == 4'd0) wiper <= clampw(f_data);
          default: ;
        endcase
      end else if (pr_rise) begin
        op   <= OP_RELOAD;
        busy <= CNT_W'(LOAD_CYC);
      end
    end
  end

  a_r4_short_frame_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bitcnt != BC_W'(FRAME_W) && idle && !pr_rise) |=> (rdy && $stable(wiper)));

  a_r9_wp_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && !wp_ok && (f_cmd == 4'd2 || f_cmd == 4'd3 || f_cmd == 4'd11))
    |=> (rdy && $stable(wiper) && $stable(nv_o)));

  a_r10_preset_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_rise && idle && !frame_ok) |=> !rdy);

  a_r6_store_at_completion: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nv_w) |-> ($past(busy) == CNT_W'(1)));

  a_r11_busy_ignores_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && busy > CNT_W'(1)) |=> (!rdy && busy == $past(busy) - 1'b1));
endmodule

// File: tb/dpot_serial_ctrl_tb.sv
module dpot_serial_ctrl_tb;
  localparam int STORE_CYC = 400;
  localparam int LOAD_CYC  = 5;
  localparam int HP        = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, wp_n = 1'b1, preset = 1'b0;
  logic sdo, rdy;
  logic [9:0] wiper;
  logic [1:0] gpo;

  int checks = 0, errors = 0, lowcnt = 0;
  bit done = 1'b0;
  logic [23:0] cap;
  int exp_w = 512, exp_nv = 512, exp_o = 0;

  always #2.5 clk = ~clk;

  dpot_serial_ctrl #(.STORE_CYC(STORE_CYC), .LOAD_CYC(LOAD_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .wp_n(wp_n), .preset(preset), .sdo(sdo), .rdy(rdy), .wiper(wiper), .gpo(gpo));

  always @(posedge clk) if (rst_n && !rdy) lowcnt <= lowcnt + 1;

  function automatic int clampf(input int d);
    return (d > 1023) ? 1023 : d;
  endfunction

  function automatic logic [31:0] fr(input int c, input int a, input int d);
    return {8'h00, 4'(c), 4'(a), 16'(d)};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input int n);
    cap = '0;
    cs_n = 1'b0;
    tick(HP);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      tick(HP);
      cap = {cap[22:0], sdo};
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
    end
    tick(HP);
    cs_n = 1'b1;
    tick(6);
  endtask

  task automatic wait_idle();
    while (!rdy) tick(1);
    tick(2);
  endtask

  task automatic run(input logic [31:0] w);
    tick(1);
    lowcnt = 0;
    send(w, 24);
    wait_idle();
  endtask

  task automatic readback(input int c, input int a, input logic [31:0] exp, input string req);
    run(fr(c, a, 0));
    check(req, lowcnt, LOAD_CYC);
    run(fr(0, 0, 0));
    check(req, {8'h0, cap}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    tick(4);
    rst_n = 1'b1;
    tick(4);
    check("R1 wiper", wiper, 512);
    check("R1 gpo", gpo, 0);
    check("R1 rdy", rdy, 1);
    check("R1 sdo", sdo, 0);

    run(fr(11, 0, 300));
    check("R2 write", wiper, 300);
    run(fr(5, 0, 77));
    check("R2 unlisted cmd", wiper, 300);
    run(fr(11, 2, 77));
    check("R2 bad addr", wiper, 300);

    run(fr(11, 0, 16'hFFFF)); check("R3 ffff", wiper, 1023);
    run(fr(11, 0, 1024));     check("R3 1024", wiper, 1023);
    run(fr(11, 0, 1023));     check("R3 1023", wiper, 1023);
    run(fr(11, 0, 0));        check("R3 zero", wiper, 0);

    tick(1); send(fr(11, 0, 40), 23); wait_idle();
    check("R4 23 bits", wiper, 0);
    tick(1); send(fr(11, 0, 40) | 32'h0100_0000, 25); wait_idle();
    check("R4 25 bits", wiper, 0);
    run(fr(11, 0, 40)); check("R4 full frame", wiper, 40);

    run(fr(0, 7, 16'hBEEF));
    run(fr(0, 3, 16'h1234));
    check("R5 echo", {8'h0, cap}, 32'h0007BEEF);
    run(fr(0, 0, 0));
    check("R5 echo 2", {8'h0, cap}, 32'h00031234);

    run(fr(11, 0, 700));
    run(fr(2, 0, 0));
    check("R6 store len", lowcnt, STORE_CYC);
    run(fr(11, 0, 100));
    run(fr(1, 0, 0));
    check("R6 restore", wiper, 700);
    check("R6 restore no busy", lowcnt, 0);

    run(fr(3, 1, 1));
    check("R7 gpo1", gpo, 1);
    check("R7 store len", lowcnt, STORE_CYC);
    run(fr(3, 1, 2)); check("R7 gpo2", gpo, 2);
    run(fr(3, 0, 2000)); check("R7 wiper untouched", wiper, 700);

    readback(9, 0, 1023, "R8 nv wiper");
    readback(10, 0, 700, "R8 live wiper");
    readback(9, 1, 2, "R8 nv outputs");

    run(fr(8, 0, 0));
    check("R12 reload", wiper, 1023);
    check("R12 len", lowcnt, LOAD_CYC);
    run(fr(11, 0, 10));
    run(fr(1, 0, 0));
    check("R12 cmd1 no busy", lowcnt, 0);

    run(fr(11, 0, 9));
    tick(1); lowcnt = 0;
    preset = 1'b1; tick(6); wait_idle(); preset = 1'b0; tick(4);
    check("R10 preset", wiper, 1023);
    check("R10 len", lowcnt, LOAD_CYC);

    run(fr(11, 0, 33));
    wp_n = 1'b0; tick(4);
    run(fr(11, 0, 44)); check("R9 write blocked", wiper, 33);
    run(fr(3, 1, 3));
    check("R9 gpo blocked", gpo, 2);
    check("R9 no busy", lowcnt, 0);
    run(fr(2, 0, 0)); check("R9 store no busy", lowcnt, 0);
    readback(9, 0, 1023, "R9 nv kept");
    run(fr(8, 0, 0)); check("R9 cmd8 allowed", wiper, 1023);
    readback(10, 1, 2, "R9 readback allowed");
    wp_n = 1'b1; tick(4);

    run(fr(11, 0, 50));
    tick(1); lowcnt = 0;
    send(fr(2, 0, 0), 24);
    send(fr(11, 0, 60), 24);
    wait_idle();
    check("R11 ignored", wiper, 50);
    check("R11 len kept", lowcnt, STORE_CYC);
    readback(9, 0, 50, "R11 store done");

    exp_w = 50;
    for (int i = 0; i < 25; i++) begin
      int d;
      d = (i % 2 == 0) ? int'($urandom_range(0, 2047)) : int'($urandom_range(0, 65535));
      run(fr(11, 0, d));
      exp_w = clampf(d);
      check("R3 random", wiper, exp_w);
      if (i % 5 == 4) readback(10, 0, exp_w, "R8 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule